// File: doc/BRIEF.md
# Hall Commutation Decoder with Reversal

This block turns the three digitized Hall sensor levels of a three-phase brushless motor into six power-stage gate enables. Each phase gets one high-side (source) enable and one low-side (sink) enable. For every legal Hall state, one phase sources current and another phase sinks it. A direction select reverses the rotation by decoding the complemented Hall code.

Speed and current control act only on the low side. The high-side switch of the active pair stays on for the whole commutation state. The low-side switch follows the PWM chop input. When the current-limit flag is raised, the low-side on-time is cut for the rest of that PWM period.

A stop request or a fault shuts off every switch. An illegal Hall code also shuts off every switch. Any change of the Hall code or of the direction select inserts a blanking interval with all enables low before the new pair is switched on.

All six enables are registered. Each output reflects the inputs sampled at the clock edge that produced it.

Top module: `bldc_commutator`

## Requirements
- R1: With `fr` = 0, the Hall code {hall[2],hall[1],hall[0]} selects the source and sink phases as follows, where phase 1, 2 and 3 are bit 0, 1 and 2 of `hi_en` and `lo_en`: 101 gives source 2 and sink 1; 100 gives source 3 and sink 1; 110 gives source 3 and sink 2; 010 gives source 1 and sink 2; 011 gives source 1 and sink 3; 001 gives source 2 and sink 3.
- R2: With `fr` = 1, the pair is the one that R1 assigns to the bitwise complement of the Hall code. For example, Hall code 010 gives source 2 and sink 1.
- R3: At most one bit of `hi_en` and at most one bit of `lo_en` is high. They are never on the same phase. A low-side enable is never on without a high-side enable.
- R4: The high-side enable of the active pair does not depend on `pwm`. The low-side enable is high only in the cycle after `pwm` was sampled high.
- R5: A cycle in which `ilim` is sampled high turns off the low-side enable in the next cycle.
- R6: Once `ilim` has been seen, the low side stays off until the next rising edge of `pwm`. That rising edge re-enables the low side, unless `ilim` is high at that same edge.
- R7: `run` sampled low or `fault_off` sampled high forces all six enables low in the next cycle.
- R8: Hall codes 000 and 111 force all six enables low.
- R9: A change of `hall` or `fr` relative to the previous cycle forces all enables low for BLANK_CYC cycles (default 1) before the new pair turns on.
- R10: While `rst` is high, and in the first cycle after it, all enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall | input | 3 | Digitized Hall levels, bit 2 = sensor 1, bit 0 = sensor 3 |
| fr | input | 1 | Direction select, 1 = reverse |
| pwm | input | 1 | PWM chop signal for the low side |
| ilim | input | 1 | Current-limit flag |
| run | input | 1 | 1 = run, 0 = stop |
| fault_off | input | 1 | Fault disable, 1 forces all off |
| hi_en | output | 3 | High-side (source) enable per phase |
| lo_en | output | 3 | Low-side (sink) enable per phase |

## Verification
The directed patterns walk all six legal Hall codes in both directions, each held long enough to leave the blanking interval. This separates the forward map from the complemented reverse map. It also exposes any swapped phase or swapped source/sink.

Held states with `pwm` toggling show that the high side is independent of the chop. Short `ilim` pulses placed in the middle of a PWM period show that the cut lasts until the next rising edge and not merely one cycle.

Random stimulus mixes rare Hall and direction changes, illegal codes, stop and fault requests, and `ilim` pulses. This shows the blanking and the priority of the forcing inputs in combinations that the directed cases do not reach.

// File: rtl/bldc_commut_pkg.sv
package bldc_commut_pkg;

    localparam int NUM_PHASES = 3;
    localparam int PH_IDX_W   = $clog2(NUM_PHASES);

    typedef logic [NUM_PHASES-1:0] phase_vec_t;
    typedef logic [PH_IDX_W-1:0]   phase_idx_t;

    // Selected conduction pair for one Hall state
    typedef struct packed {
        logic       valid;
        phase_idx_t src;
        phase_idx_t snk;
    } conduct_t;

    // Gate enable bundle
    typedef struct packed {
        phase_vec_t hi;
        phase_vec_t lo;
    } gate_t;

    // Forward-direction code table; index 0 = phase 1
    function automatic conduct_t decode_hall(input logic [2:0] code);
        conduct_t c;
        c = '0;
        c.valid = 1'b1;
        unique case (code)
            3'b101: begin c.src = 2'd1; c.snk = 2'd0; end
            3'b100: begin c.src = 2'd2; c.snk = 2'd0; end
            3'b110: begin c.src = 2'd2; c.snk = 2'd1; end
            3'b010: begin c.src = 2'd0; c.snk = 2'd1; end
            3'b011: begin c.src = 2'd0; c.snk = 2'd2; end
            3'b001: begin c.src = 2'd1; c.snk = 2'd2; end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic phase_vec_t idx_to_vec(input phase_idx_t idx);
        phase_vec_t v;
        v = '0;
        for (int k = 0; k < NUM_PHASES; k++) begin
            if (idx == phase_idx_t'(k)) v[k] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/hall_phase_decode.sv
module hall_phase_decode
    import bldc_commut_pkg::*;
(
    input  logic [2:0] hall,
    input  logic       fr,
    output conduct_t   pair
);
    logic [2:0] code;

    // Reverse rotation uses the complemented Hall code
    assign code = fr ? ~hall : hall;

    always_comb begin
        pair = decode_hall(code);
    end
endmodule

// File: rtl/commut_blank.sv
module commut_blank #(
    parameter int BLANK_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall,
    input  logic       fr,
    output logic       blank
);
    localparam int CNT_W = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;

    logic [2:0]       hall_q;
    logic             fr_q;
    logic [CNT_W-1:0] hold_cnt;
    logic             edge_seen;

    assign edge_seen = (hall != hall_q) || (fr != fr_q);
    assign blank     = edge_seen || (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hall_q   <= '0;
            fr_q     <= 1'b0;
            hold_cnt <= '0;
        end else begin
            hall_q <= hall;
            fr_q   <= fr;
            if (edge_seen)
                hold_cnt <= CNT_W'(BLANK_CYC - 1);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/lowside_chop.sv
module lowside_chop (
    input  logic clk,
    input  logic rst,
    input  logic pwm,
    input  logic ilim,
    output logic chop_on
);
    logic pwm_q;
    logic lim_hold;
    logic pwm_rise;
    logic cut;

    assign pwm_rise = pwm && !pwm_q;
    assign cut      = ilim || (lim_hold && !pwm_rise);
    assign chop_on  = pwm && !cut;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q    <= 1'b0;
            lim_hold <= 1'b0;
        end else begin
            pwm_q <= pwm;
            if (pwm_rise)
                lim_hold <= ilim;
            else
                lim_hold <= lim_hold || ilim;
        end
    end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_commut_pkg::*;
#(
    parameter int BLANK_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall,
    input  logic       fr,
    input  logic       pwm,
    input  logic       ilim,
    input  logic       run,
    input  logic       fault_off,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en
);
    conduct_t pair;
    logic     blank;
    logic     chop_on;
    logic     allow;
    gate_t    gate_d;
    gate_t    gate_q;

    hall_phase_decode u_decode (
        .hall (hall),
        .fr   (fr),
        .pair (pair)
    );

    commut_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk   (clk),
        .rst   (rst),
        .hall  (hall),
        .fr    (fr),
        .blank (blank)
    );

    lowside_chop u_chop (
        .clk     (clk),
        .rst     (rst),
        .pwm     (pwm),
        .ilim    (ilim),
        .chop_on (chop_on)
    );

    assign allow = run && !fault_off && !blank && pair.valid;

    always_comb begin
        gate_d = '0;
        if (allow) begin
            gate_d.hi = idx_to_vec(pair.src);
            if (chop_on) gate_d.lo = idx_to_vec(pair.snk);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_d;
    end

    assign hi_en = gate_q.hi;
    assign lo_en = gate_q.lo;
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] hall,
    input logic       fr,
    input logic       pwm,
    input logic       ilim,
    input logic       run,
    input logic       fault_off,
    input logic [2:0] hi_en,
    input logic [2:0] lo_en
);
    p_one_pair_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hi_en) && $onehot0(lo_en) && ((hi_en & lo_en) == 3'b000));

    p_low_needs_high_r3: assert property (@(posedge clk) disable iff (rst)
        (lo_en != 3'b000) |-> (hi_en != 3'b000));

    p_low_follows_pwm_r4: assert property (@(posedge clk) disable iff (rst)
        (lo_en != 3'b000) |-> $past(pwm));

    p_ilim_cuts_r5: assert property (@(posedge clk) disable iff (rst)
        $past(ilim) |-> (lo_en == 3'b000));

    p_stop_fault_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!run) || $past(fault_off)) |-> (hi_en == 3'b000 && lo_en == 3'b000));

    p_illegal_hall_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(hall) == 3'b000 || $past(hall) == 3'b111) |-> (hi_en == 3'b000));

    p_change_blank_r9: assert property (@(posedge clk) disable iff (rst)
        (($past(hall) != $past(hall, 2)) || ($past(fr) != $past(fr, 2)))
        |-> (hi_en == 3'b000 && lo_en == 3'b000));

    p_reset_off_r10: assert property (@(posedge clk)
        $past(rst) |-> (hi_en == 3'b000 && lo_en == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hall      (hall),
    .fr        (fr),
    .pwm       (pwm),
    .ilim      (ilim),
    .run       (run),
    .fault_off (fault_off),
    .hi_en     (hi_en),
    .lo_en     (lo_en)
);

// File: tb/test_bldc_commutator.sv
`timescale 1ns/1ps
module test_bldc_commutator;
    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall = 3'b000;
    logic       fr = 1'b0, pwm = 1'b0, ilim = 1'b0, run = 1'b0, fault_off = 1'b0;
    logic [2:0] hi_en, lo_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [2:0] m_hall = 3'b000;
    logic       m_fr = 1'b0, m_pwm = 1'b0, m_hold = 1'b0;
    logic [2:0] exp_hi = 3'b000, exp_lo = 3'b000;
    string      exp_tag = "R10";

    bldc_commutator i_bldc_commutator (
        .clk(clk), .rst(rst), .hall(hall), .fr(fr), .pwm(pwm), .ilim(ilim),
        .run(run), .fault_off(fault_off), .hi_en(hi_en), .lo_en(lo_en)
    );

    always #(HALF) clk = ~clk;

    // Forward table, bit 0 = phase 1; returns {hi, lo}
    function automatic logic [5:0] fwd_pair(input logic [2:0] c);
        case (c)
            3'b101:  return {3'b010, 3'b001};
            3'b100:  return {3'b100, 3'b001};
            3'b110:  return {3'b100, 3'b010};
            3'b010:  return {3'b001, 3'b010};
            3'b011:  return {3'b001, 3'b100};
            3'b001:  return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic check_now();
        checks++;
        if (hi_en !== exp_hi || lo_en !== exp_lo) begin
            errors++;
            $display("FAIL %s: hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b",
                     exp_tag, hi_en, lo_en, exp_hi, exp_lo);
        end
        checks++;
        if (((hi_en & lo_en) != 3'b000) || $countones(hi_en) > 1 || $countones(lo_en) > 1) begin
            errors++;
            $display("FAIL R3: hi_en=%b lo_en=%b expected disjoint one-hot pair", hi_en, lo_en);
        end
    endtask

    task automatic step(input logic [2:0] h, input logic f, input logic p,
                        input logic i, input logic r, input logic fo);
        logic chg, rise, cut;
        logic [5:0] pr;
        @(negedge clk);
        check_now();
        hall = h; fr = f; pwm = p; ilim = i; run = r; fault_off = fo;
        chg  = (h != m_hall) || (f != m_fr);
        rise = p && !m_pwm;
        cut  = i || (m_hold && !rise);
        pr   = fwd_pair(f ? ~h : h);
        exp_hi = 3'b000; exp_lo = 3'b000;
        if (!r || fo)              exp_tag = "R7";
        else if (pr == 6'b0)       exp_tag = "R8";
        else if (chg)              exp_tag = "R9";
        else begin
            exp_hi = pr[5:3];
            if (!p)               exp_tag = "R4";
            else if (i)           exp_tag = "R5";
            else if (cut)         exp_tag = "R6";
            else begin
                exp_lo  = pr[2:0];
                exp_tag = f ? "R2" : "R1";
            end
        end
        m_hall = h; m_fr = f; m_pwm = p;
        m_hold = rise ? i : (m_hold || i);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [2:0] codes [6];
        logic [2:0] h;
        logic f, r, fo;
        int per, duty;
        seed = $urandom(32'd2024);
        codes[0] = 3'b101; codes[1] = 3'b100; codes[2] = 3'b110;
        codes[3] = 3'b010; codes[4] = 3'b011; codes[5] = 3'b001;

        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_tag = "R10";
        check_now();
        rst = 1'b0;
        exp_hi = 3'b000; exp_lo = 3'b000; exp_tag = "R10";

        // R1 and R2: every code in both directions, pwm toggling (R4)
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 6; k++) begin
                for (int c = 0; c < 6; c++)
                    step(codes[k], d[0], c[0], 1'b0, 1'b1, 1'b0);
            end
        end

        // R8: illegal codes
        for (int c = 0; c < 4; c++) step(3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int c = 0; c < 4; c++) step(3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

        // R5 and R6: ilim pulse in mid-period holds the cut until the next pwm rise
        for (int c = 0; c < 3; c++) step(3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        step(3'b110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int c = 0; c < 3; c++) step(3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        step(3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int c = 0; c < 3; c++) step(3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        // ilim high at the rising edge itself keeps the low side off
        step(3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(3'b110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int c = 0; c < 2; c++) step(3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

        // R7: stop and fault
        for (int c = 0; c < 3; c++) step(3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int c = 0; c < 3; c++) step(3'b011, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int c = 0; c < 3; c++) step(3'b011, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

        // R9: direction flip alone blanks
        for (int c = 0; c < 3; c++) step(3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

        // Random mix
        h = 3'b101; f = 1'b0; r = 1'b1; fo = 1'b0;
        per = 8; duty = 5;
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(5) == 0) h = codes[$urandom_range(5)];
            if ($urandom_range(59) == 0) h = ($urandom_range(1) == 0) ? 3'b000 : 3'b111;
            if ($urandom_range(49) == 0) f = ~f;
            r  = ($urandom_range(59) != 0);
            fo = ($urandom_range(79) == 0);
            if ((n % per) == 0) duty = $urandom_range(per - 1, 1);
            step(h, f, ((n % per) < duty), ($urandom_range(11) == 0), r, fo);
        end

        @(negedge clk);
        check_now();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule